// File: doc/BRIEF.md
# Preemptive Conversion Request Arbiter

This block sits in front of one analog-to-digital converter unit and decides which of its 32 activation channels converts next. A channel raises its bit in the request vector for at least one cycle, and the block latches it as pending. Each channel has a configured 2-bit priority and a 6-bit analog input number. When the converter is free, the block picks a winner and pulses a start trigger, while the winner's analog input number appears on the channel output. When the converter reports completion, the block pulses a done strobe and reports the index of the channel it served.

A pending request of strictly higher priority can interrupt a running conversion. The block pulses cancel for one cycle and starts the new winner in the next cycle. The interrupted request stays pending inside the block and is served again once arbitration resumes, so the channel does not need to request again. A second unit built from the same block serves channels 32 to 63.

Top module: `adc_preempt_arbiter`

## Requirements
- R1: After reset, startPulse, cancelPulse and doneValid are low, actIdx and anaChan are zero, and no request is pending.
- R2: While no conversion is running, the pending request with the largest priority value wins. Channel i's priority is prioFlat[2i+1:2i], and a larger value means higher priority.
- R3: Among pending requests of equal top priority, the one with the lowest channel index wins.
- R4: Each grant produces a single-cycle startPulse. While it is high, actIdx holds the winner and anaChan holds anaSelFlat[6w+5:6w] of winner w.
- R5: While a conversion runs, a pending request of strictly higher priority causes a one-cycle cancelPulse. In the next cycle, startPulse is asserted for the new winner.
- R6: A request of equal or lower priority that arrives during a conversion causes no cancel. It is granted only after convDone.
- R7: After a preempting conversion completes, arbitration runs again and the interrupted channel is granted again.
- R8: convDone during a conversion gives doneValid one cycle later, with actIdx holding the finished channel. That channel's pending state is cleared, so it is not granted again unless it requests again.
- R9: If convDone and a preempting request fall in the same cycle, completion wins: doneValid is pulsed, there is no cancelPulse, and the other request is granted next.
- R10: convDone is ignored while no conversion is running, including the cycle after a cancel. No doneValid results from it.
- R11: A preempted request is not lost, even if its request bit is never asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqVec | input | 32 | Per-channel request, latched as pending |
| prioFlat | input | 64 | 2-bit priority per channel, larger is higher |
| anaSelFlat | input | 192 | 6-bit analog input number per channel |
| convDone | input | 1 | Converter finished the current conversion |
| startPulse | output | 1 | Start trigger to the converter |
| cancelPulse | output | 1 | Abort of the running conversion |
| anaChan | output | 6 | Analog input number for the granted channel |
| actIdx | output | 5 | Granted channel, also the finished channel when doneValid is high |
| doneValid | output | 1 | Completion strobe back to the channels |

## Verification
Completion of the running conversion and preemption by a strictly higher-priority request can land in the same clock. The bench provokes this by making a priority-3 request pending exactly in the cycle where it drives convDone. The expected result is a done strobe for the old channel with no cancel, followed one cycle later by a start for the new one. A related collision, convDone arriving in the cancel cycle itself, is also driven, and the bench expects it to be dropped.

// File: rtl/adc_arb_pkg.sv
package adc_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CONV   = 2'd1,
    ST_CANCEL = 2'd2
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic grab;    // latch current winner as active channel
    logic retire;  // active conversion finished, drop its pending bit
  } arbStrobe_t;

endpackage

// File: rtl/adc_arb_datapath.sv
module adc_arb_datapath
  import adc_arb_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int PRIO_W = 2,
  parameter int ANA_W  = 6,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         reqVec,
  input  logic [NUM_CH*PRIO_W-1:0]  prioFlat,
  input  logic [NUM_CH*ANA_W-1:0]   anaSelFlat,
  input  arbStrobe_t                strb,
  output logic                      hasWinner,
  output logic                      preemptReq,
  output logic [IDX_W-1:0]          activeIdx,
  output logic [ANA_W-1:0]          anaChan
);

  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] clrMask;
  logic [PRIO_W-1:0] chPrio [NUM_CH];
  logic [ANA_W-1:0]  chAna  [NUM_CH];
  logic [IDX_W-1:0]  winIdx;
  logic [PRIO_W-1:0] winPrio;
  logic [PRIO_W-1:0] activePrio;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign chPrio[g] = prioFlat[g*PRIO_W +: PRIO_W];
    assign chAna[g]  = anaSelFlat[g*ANA_W +: ANA_W];
  end

  // scan downward with >= so the lowest index keeps ties
  always_comb begin
    hasWinner = 1'b0;
    winIdx    = '0;
    winPrio   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend[i] && (!hasWinner || chPrio[i] >= winPrio)) begin
        hasWinner = 1'b1;
        winIdx    = IDX_W'(i);
        winPrio   = chPrio[i];
      end
    end
  end

  assign preemptReq = hasWinner && (winPrio > activePrio);

  always_comb begin
    clrMask = '0;
    if (strb.retire) clrMask[activeIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= '0;
      activeIdx  <= '0;
      activePrio <= '0;
      anaChan    <= '0;
    end else begin
      pend <= (pend & ~clrMask) | reqVec;
      if (strb.grab) begin
        activeIdx  <= winIdx;
        activePrio <= winPrio;
        anaChan    <= chAna[winIdx];
      end
    end
  end

  a_r2_grab_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    strb.grab |-> hasWinner && pend[winIdx]);

  a_r8_retire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.retire && !reqVec[activeIdx]) |=> !pend[$past(activeIdx)]);

  a_r11_active_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[activeIdx] && !strb.retire) |=> pend[$past(activeIdx)]);

endmodule

// File: rtl/adc_arb_control.sv
module adc_arb_control
  import adc_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       convDone,
  input  logic       hasWinner,
  input  logic       preemptReq,
  output arbStrobe_t strb,
  output logic       startPulse,
  output logic       cancelPulse,
  output logic       doneValid
);

  arbState_t state, stateNxt;
  logic      abortNow;

  always_comb begin
    stateNxt    = state;
    strb.grab   = 1'b0;
    strb.retire = 1'b0;
    abortNow    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (hasWinner) begin
          strb.grab = 1'b1;
          stateNxt  = ST_CONV;
        end
      end
      ST_CONV: begin
        if (convDone) begin
          strb.retire = 1'b1;
          stateNxt    = ST_IDLE;
        end else if (preemptReq) begin
          abortNow = 1'b1;
          stateNxt = ST_CANCEL;
        end
      end
      ST_CANCEL: begin
        strb.grab = 1'b1;
        stateNxt  = ST_CONV;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      startPulse  <= 1'b0;
      cancelPulse <= 1'b0;
      doneValid   <= 1'b0;
    end else begin
      state       <= stateNxt;
      startPulse  <= strb.grab;
      cancelPulse <= abortNow;
      doneValid   <= strb.retire;
    end
  end

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> !startPulse);

  a_r5_cancel_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    cancelPulse |=> startPulse);

  a_r9_done_excludes_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    !(cancelPulse && doneValid));

  a_r10_done_needs_conv: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> $past(state) == ST_CONV);

endmodule

// File: rtl/adc_preempt_arbiter.sv
module adc_preempt_arbiter
  import adc_arb_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int PRIO_W = 2,
  parameter int ANA_W  = 6,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        reqVec,
  input  logic [NUM_CH*PRIO_W-1:0] prioFlat,
  input  logic [NUM_CH*ANA_W-1:0]  anaSelFlat,
  input  logic                     convDone,
  output logic                     startPulse,
  output logic                     cancelPulse,
  output logic [ANA_W-1:0]         anaChan,
  output logic [IDX_W-1:0]         actIdx,
  output logic                     doneValid
);

  arbStrobe_t strb;
  logic       hasWinner;
  logic       preemptReq;

  adc_arb_datapath #(
    .NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .ANA_W(ANA_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .reqVec(reqVec), .prioFlat(prioFlat),
    .anaSelFlat(anaSelFlat), .strb(strb), .hasWinner(hasWinner),
    .preemptReq(preemptReq), .activeIdx(actIdx), .anaChan(anaChan)
  );

  adc_arb_control ctl_i (
    .clk(clk), .rst_n(rst_n), .convDone(convDone), .hasWinner(hasWinner),
    .preemptReq(preemptReq), .strb(strb), .startPulse(startPulse),
    .cancelPulse(cancelPulse), .doneValid(doneValid)
  );

endmodule

// File: tb/adc_preempt_arbiter_tb.sv
module adc_preempt_arbiter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] reqVec = '0;
  logic [63:0] prioFlat = '0;
  logic [191:0] anaSelFlat;
  logic        convDone = 1'b0;
  logic        startPulse, cancelPulse, doneValid;
  logic [5:0]  anaChan;
  logic [4:0]  actIdx;

  int nChk = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  adc_preempt_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .reqVec(reqVec), .prioFlat(prioFlat),
    .anaSelFlat(anaSelFlat), .convDone(convDone), .startPulse(startPulse),
    .cancelPulse(cancelPulse), .anaChan(anaChan), .actIdx(actIdx),
    .doneValid(doneValid)
  );

  typedef struct packed {
    logic [31:0] mask;
    logic [4:0] chA; logic [1:0] pA;
    logic [4:0] chB; logic [1:0] pB;
    logic [4:0] chC; logic [1:0] pC;
    logic [4:0] expIdx;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0020, 5'd5,  2'd0, 5'd0,  2'd0, 5'd0,  2'd0, 5'd5},
    '{32'h0000_0208, 5'd9,  2'd3, 5'd3,  2'd1, 5'd0,  2'd0, 5'd9},
    '{32'h0010_0090, 5'd4,  2'd2, 5'd7,  2'd2, 5'd20, 2'd2, 5'd4},
    '{32'h8000_0001, 5'd31, 2'd1, 5'd0,  2'd0, 5'd0,  2'd0, 5'd31},
    '{32'hFFFF_FFFF, 5'd0,  2'd0, 5'd0,  2'd0, 5'd0,  2'd0, 5'd0},
    '{32'h4000_0C00, 5'd10, 2'd2, 5'd11, 2'd2, 5'd30, 2'd3, 5'd30},
    '{32'h0000_3000, 5'd13, 2'd3, 5'd12, 2'd3, 5'd0,  2'd0, 5'd12}
  };

  function automatic logic [5:0] anaOf(int ch);
    return 6'((ch * 5 + 3) % 64);
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) anaSelFlat[i*6 +: 6] = anaOf(i);
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0; reqVec = '0; convDone = 1'b0;
    cyc(); cyc();
    rst_n = 1'b1;
  endtask

  task automatic setPrio(input int ch, input int p);
    prioFlat[ch*2 +: 2] = 2'(p);
  endtask

  task automatic pulseReq(input logic [31:0] m);
    reqVec = m; cyc(); reqVec = '0;
  endtask

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    // R1 reset state
    doReset();
    cyc();
    chk(!startPulse && !cancelPulse && !doneValid, "R1 strobes", startPulse, 0);
    chk(actIdx == 0 && anaChan == 0, "R1 idx/ana", actIdx, 0);
    // R10 done while idle is ignored; R1 nothing pending -> no start
    convDone = 1'b1; cyc(); convDone = 1'b0;
    chk(!doneValid, "R10 idle done", doneValid, 0);
    cyc();
    chk(!startPulse, "R1 nothing pending", startPulse, 0);

    // table walk: R2, R3, R4
    for (int v = 0; v < NV; v++) begin
      doReset();
      prioFlat = '0;
      setPrio(VECS[v].chA, VECS[v].pA);
      setPrio(VECS[v].chB, VECS[v].pB);
      setPrio(VECS[v].chC, VECS[v].pC);
      pulseReq(VECS[v].mask);
      cyc();
      chk(startPulse && actIdx == VECS[v].expIdx, "R2 R3 winner", actIdx, VECS[v].expIdx);
      chk(anaChan == anaOf(VECS[v].expIdx), "R4 analog number", anaChan, anaOf(VECS[v].expIdx));
    end

    // preemption: R5, R7, R8, R10, R11
    doReset();
    prioFlat = '0; setPrio(2, 1); setPrio(8, 3);
    pulseReq(32'h1 << 2);
    cyc();
    chk(startPulse && actIdx == 2, "R4 start ch2", actIdx, 2);
    reqVec = 32'h1 << 8; cyc(); reqVec = '0;
    chk(!startPulse && !cancelPulse, "R4 start single", startPulse, 0);
    cyc();
    chk(cancelPulse && !startPulse, "R5 cancel", cancelPulse, 1);
    convDone = 1'b1; cyc(); convDone = 1'b0;
    chk(startPulse && actIdx == 8, "R5 start after cancel", actIdx, 8);
    chk(!doneValid, "R10 done in cancel cycle", doneValid, 0);
    chk(anaChan == anaOf(8), "R4 ana ch8", anaChan, anaOf(8));
    cyc();
    chk(!cancelPulse, "R5 cancel single", cancelPulse, 0);
    convDone = 1'b1; cyc(); convDone = 1'b0;
    chk(doneValid && actIdx == 8, "R8 done ch8", actIdx, 8);
    cyc();
    chk(startPulse && actIdx == 2, "R7 R11 resume ch2", actIdx, 2);
    convDone = 1'b1; cyc(); convDone = 1'b0;
    chk(doneValid && actIdx == 2, "R8 done ch2", actIdx, 2);
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk(!startPulse, "R8 no regrant", startPulse, 0);
    end

    // equal / lower priority: R6
    doReset();
    prioFlat = '0; setPrio(1, 2); setPrio(0, 2); setPrio(3, 1);
    pulseReq(32'h1 << 1);
    cyc();
    chk(startPulse && actIdx == 1, "R6 start ch1", actIdx, 1);
    pulseReq(32'h9);
    for (int k = 0; k < 3; k++) begin
      chk(!cancelPulse && !startPulse, "R6 no preempt", cancelPulse, 0);
      cyc();
    end
    convDone = 1'b1; cyc(); convDone = 1'b0;
    chk(doneValid && actIdx == 1, "R6 done ch1", actIdx, 1);
    cyc();
    chk(startPulse && actIdx == 0, "R6 next ch0", actIdx, 0);
    convDone = 1'b1; cyc(); convDone = 1'b0;
    cyc();
    chk(startPulse && actIdx == 3, "R6 then ch3", actIdx, 3);

    // collision of done and preemption: R9
    doReset();
    prioFlat = '0; setPrio(5, 0); setPrio(6, 3);
    pulseReq(32'h1 << 5);
    cyc();
    chk(startPulse && actIdx == 5, "R9 start ch5", actIdx, 5);
    reqVec = 32'h1 << 6; cyc(); reqVec = '0;
    convDone = 1'b1; cyc(); convDone = 1'b0;
    chk(doneValid && actIdx == 5, "R9 done wins", actIdx, 5);
    chk(!cancelPulse, "R9 no cancel", cancelPulse, 0);
    cyc();
    chk(startPulse && actIdx == 6, "R9 then ch6", actIdx, 6);

    finish();
  end

endmodule